// File: doc/BRIEF.md
# Low-Power Wait-for-Interrupt Clock Controller

This block decides which source feeds the system clock and whether the PLL and the crystal oscillator stay powered, and it gates the CPU clock around a wait-for-interrupt (WFI) state. When the core executes WFI it pulses an entry strobe. The controller then closes the CPU clock gate. If low-power-on-WFI is enabled, it also moves the system clock to a slow source. That source is either the base clock divided by 16 or an auxiliary clock, and the auxiliary clock is used only when a presence status confirms that it is running. Peripherals keep running from whichever source is selected.

An interrupt wakes the core by reopening the CPU clock gate. It leaves the clock configuration as it is. Software returns to a fast clock by writing a new source and PLL setting through a write strobe. The same write path lets software pick any of the slow settings at any time, not only inside WFI. The glitch-free clock multiplexer and the oscillators themselves lie outside this block. They are driven by the source-select code and the two enable outputs.

Source codes used on `sw_src_i` and `src_sel_o`: 0 = PLL output, 1 = base clock, 2 = base clock / 16, 3 = auxiliary clock. All inputs are synchronous to `clk_i`, and every output is registered.

Top module: `wfi_clkctl`

## Requirements
- R1: After reset, `src_sel_o` = 1 (base clock), `pll_en_o` = 0, `xtal_en_o` = 1 and `cpu_clk_en_o` = 1.
- R2: A `wfi_enter_i` pulse while running, with `irq_i` low, drives `cpu_clk_en_o` low on the next clock. With `lp_wfi_en_i` = 0 the source and the PLL enable are left unchanged.
- R3: With `lp_wfi_en_i` = 1, a WFI entry sets `src_sel_o` to 2 (base/16) and `pll_en_o` to 0 on the next clock, unless the auxiliary clock is chosen (R5) or the PLL is kept (R4).
- R4: When `pll_keep_i` = 1 at a low-power WFI entry, `pll_en_o` keeps its value.
- R5: When `wfi_aux_sel_i` = 1 and `aux_present_i` = 1 at a low-power WFI entry, `src_sel_o` becomes 3 and `xtal_en_o` drops to 0 on the next clock, even if `xtal_stop_i` = 0.
- R6: When `wfi_aux_sel_i` = 1 but `aux_present_i` = 0 at a low-power WFI entry, `src_sel_o` becomes 2 and `xtal_en_o` stays 1.
- R7: `xtal_stop_i` lowers `xtal_en_o` only while the auxiliary clock is both present and selected. With any other source, `xtal_en_o` is 1.
- R8: `irq_i` while the gate is closed reopens `cpu_clk_en_o` on the next clock and leaves `src_sel_o` and `pll_en_o` unchanged.
- R9: A `sw_write_i` pulse loads `sw_src_i` into `src_sel_o` on the next clock, both inside and outside WFI. `pll_en_o` becomes `sw_pll_en_i`, and it is forced to 1 when the source is 0. The write does not change `cpu_clk_en_o` and cancels the automatic crystal stop.
- R10: A software write of source 3 while `aux_present_i` = 0 selects source 2 instead. The auxiliary source is never output in the clock after `aux_present_i` was sampled low.
- R11: If `aux_present_i` falls while source 3 is selected, `src_sel_o` falls back to 2 and `xtal_en_o` returns to 1 on the next clock.
- R12: `wfi_enter_i` is ignored when it coincides with `irq_i` or arrives while the gate is already closed. A low-power WFI entry takes priority over a software write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wfi_enter_i | input | 1 | One-cycle pulse when the core executes WFI |
| irq_i | input | 1 | Wake-up interrupt request |
| lp_wfi_en_i | input | 1 | Enable slow clock and PLL shutdown on WFI |
| wfi_aux_sel_i | input | 1 | Prefer the auxiliary clock, with automatic crystal stop, on WFI |
| xtal_stop_i | input | 1 | Request to stop the crystal while the auxiliary clock runs |
| pll_keep_i | input | 1 | Keep the PLL powered through a low-power WFI |
| aux_present_i | input | 1 | Auxiliary clock detected and running |
| sw_write_i | input | 1 | Software configuration write strobe |
| sw_src_i | input | 2 | Source code requested by software |
| sw_pll_en_i | input | 1 | PLL enable requested by software |
| src_sel_o | output | 2 | Source select for the clock multiplexer |
| pll_en_o | output | 1 | PLL power enable |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |

## Verification
The checker assumes that every input is already synchronous to `clk_i`. In particular, `aux_present_i` must come from a synchronizer, so that a fall seen at one edge is the same fall the source logic acts on. It also assumes that `wfi_enter_i` and `sw_write_i` are single-cycle strobes. The stimulus keeps to these conditions by changing every input at the falling edge. Each strobe is held for exactly one cycle. Interrupts are raised only as short pulses, and collisions between entry, wake-up and write are produced on purpose in a dedicated scenario.

// File: rtl/wfi_clkctl_pkg.sv
package wfi_clkctl_pkg;
  localparam int SRC_W = 2;

  typedef enum logic [SRC_W-1:0] {
    SRC_PLL   = 2'd0,
    SRC_BASE  = 2'd1,
    SRC_DIV16 = 2'd2,
    SRC_AUX   = 2'd3
  } clk_src_e;

  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_SLEEP = 1'b1
  } sleep_st_e;
endpackage

// File: rtl/wfi_sleep_ctl.sv
module wfi_sleep_ctl
  import wfi_clkctl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wfi_enter_i,
  input  logic irq_i,
  input  logic lp_wfi_en_i,
  output logic lp_enter_o,
  output logic cpu_clk_en_o
);
  sleep_st_e st_q, st_d;
  logic      enter_ok;

  // An entry counts only from the running state and never together with a wake-up.
  assign enter_ok   = wfi_enter_i && !irq_i && (st_q == ST_RUN);
  assign lp_enter_o = enter_ok && lp_wfi_en_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:   if (enter_ok) st_d = ST_SLEEP;
      ST_SLEEP: if (irq_i)    st_d = ST_RUN;
      default:                st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_RUN;
      cpu_clk_en_o <= 1'b1;
    end else begin
      st_q         <= st_d;
      cpu_clk_en_o <= (st_d == ST_RUN);
    end
  end
endmodule

// File: rtl/wfi_src_sel.sv
module wfi_src_sel
  import wfi_clkctl_pkg::*;
#(
  parameter logic [SRC_W-1:0] RST_SRC = SRC_BASE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lp_enter_i,
  input  logic             wfi_aux_sel_i,
  input  logic             aux_present_i,
  input  logic             sw_write_i,
  input  logic [SRC_W-1:0] sw_src_i,
  output logic [SRC_W-1:0] src_next_o,
  output logic [SRC_W-1:0] src_q_o
);
  logic [SRC_W-1:0] sw_src_ok;

  // Software cannot pick a missing auxiliary clock; it lands on base/16.
  assign sw_src_ok = (sw_src_i == SRC_AUX && !aux_present_i) ? SRC_DIV16 : sw_src_i;

  always_comb begin
    src_next_o = src_q_o;
    if (lp_enter_i) begin
      src_next_o = (wfi_aux_sel_i && aux_present_i) ? SRC_AUX : SRC_DIV16;
    end else if (sw_write_i) begin
      src_next_o = sw_src_ok;
    end else if (src_q_o == SRC_AUX && !aux_present_i) begin
      src_next_o = SRC_DIV16;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q_o <= RST_SRC;
    else         src_q_o <= src_next_o;
  end
endmodule

// File: rtl/wfi_osc_ctl.sv
module wfi_osc_ctl
  import wfi_clkctl_pkg::*;
#(
  parameter logic RST_PLL_EN = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lp_enter_i,
  input  logic             wfi_aux_sel_i,
  input  logic             aux_present_i,
  input  logic             xtal_stop_i,
  input  logic             pll_keep_i,
  input  logic             sw_write_i,
  input  logic [SRC_W-1:0] sw_src_i,
  input  logic             sw_pll_en_i,
  input  logic [SRC_W-1:0] src_next_i,
  output logic             pll_en_o,
  output logic             xtal_en_o
);
  logic pll_d;
  logic auto_q, auto_d;
  logic aux_live;

  assign aux_live = (src_next_i == SRC_AUX) && aux_present_i;

  always_comb begin
    pll_d = pll_en_o;
    if (lp_enter_i) begin
      pll_d = pll_keep_i ? pll_en_o : 1'b0;
    end else if (sw_write_i) begin
      pll_d = sw_pll_en_i || (sw_src_i == SRC_PLL);
    end
  end

  // The automatic crystal stop lasts from a low-power entry on the auxiliary clock
  // until software writes or the auxiliary source is left.
  always_comb begin
    auto_d = auto_q;
    if (lp_enter_i)           auto_d = wfi_aux_sel_i && aux_present_i;
    else if (sw_write_i)      auto_d = 1'b0;
    if (!aux_live)            auto_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pll_en_o  <= RST_PLL_EN;
      auto_q    <= 1'b0;
      xtal_en_o <= 1'b1;
    end else begin
      pll_en_o  <= pll_d;
      auto_q    <= auto_d;
      xtal_en_o <= !(aux_live && (xtal_stop_i || auto_d));
    end
  end
endmodule

// File: rtl/wfi_clkctl.sv
module wfi_clkctl
  import wfi_clkctl_pkg::*;
#(
  parameter logic [1:0] RST_SRC    = 2'd1,
  parameter logic       RST_PLL_EN = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wfi_enter_i,
  input  logic       irq_i,
  input  logic       lp_wfi_en_i,
  input  logic       wfi_aux_sel_i,
  input  logic       xtal_stop_i,
  input  logic       pll_keep_i,
  input  logic       aux_present_i,
  input  logic       sw_write_i,
  input  logic [1:0] sw_src_i,
  input  logic       sw_pll_en_i,
  output logic [1:0] src_sel_o,
  output logic       pll_en_o,
  output logic       xtal_en_o,
  output logic       cpu_clk_en_o
);
  logic             lp_enter;
  logic [SRC_W-1:0] src_next;

  wfi_sleep_ctl u_sleep (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wfi_enter_i  (wfi_enter_i),
    .irq_i        (irq_i),
    .lp_wfi_en_i  (lp_wfi_en_i),
    .lp_enter_o   (lp_enter),
    .cpu_clk_en_o (cpu_clk_en_o)
  );

  wfi_src_sel #(.RST_SRC(RST_SRC)) u_src (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .lp_enter_i    (lp_enter),
    .wfi_aux_sel_i (wfi_aux_sel_i),
    .aux_present_i (aux_present_i),
    .sw_write_i    (sw_write_i),
    .sw_src_i      (sw_src_i),
    .src_next_o    (src_next),
    .src_q_o       (src_sel_o)
  );

  wfi_osc_ctl #(.RST_PLL_EN(RST_PLL_EN)) u_osc (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .lp_enter_i    (lp_enter),
    .wfi_aux_sel_i (wfi_aux_sel_i),
    .aux_present_i (aux_present_i),
    .xtal_stop_i   (xtal_stop_i),
    .pll_keep_i    (pll_keep_i),
    .sw_write_i    (sw_write_i),
    .sw_src_i      (sw_src_i),
    .sw_pll_en_i   (sw_pll_en_i),
    .src_next_i    (src_next),
    .pll_en_o      (pll_en_o),
    .xtal_en_o     (xtal_en_o)
  );
endmodule

// File: rtl/wfi_clkctl_chk.sv
module wfi_clkctl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wfi_enter_i,
  input logic       irq_i,
  input logic       lp_wfi_en_i,
  input logic       wfi_aux_sel_i,
  input logic       pll_keep_i,
  input logic       aux_present_i,
  input logic       sw_write_i,
  input logic [1:0] src_sel_o,
  input logic       pll_en_o,
  input logic       xtal_en_o,
  input logic       cpu_clk_en_o
);
  // R2
  gate_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clk_en_o && wfi_enter_i && !irq_i |=> !cpu_clk_en_o);

  // R3
  pll_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clk_en_o && wfi_enter_i && !irq_i && lp_wfi_en_i && !pll_keep_i |=> !pll_en_o);

  // R4
  pll_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clk_en_o && wfi_enter_i && !irq_i && lp_wfi_en_i && pll_keep_i |=> $stable(pll_en_o));

  // R7
  xtal_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_o != 2'd3) |-> xtal_en_o);

  // R8
  wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_clk_en_o && irq_i && !sw_write_i && aux_present_i |=> cpu_clk_en_o && $stable(src_sel_o));

  // R10
  no_absent_aux_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aux_present_i |=> (src_sel_o != 2'd3));

  // R11
  fallback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_o == 2'd3) && !aux_present_i && !sw_write_i |=> (src_sel_o == 2'd2) && xtal_en_o);

  // R5
  aux_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clk_en_o && wfi_enter_i && !irq_i && lp_wfi_en_i && wfi_aux_sel_i && aux_present_i
    |=> (src_sel_o == 2'd3) && !xtal_en_o);
endmodule

bind wfi_clkctl wfi_clkctl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wfi_enter_i   (wfi_enter_i),
  .irq_i         (irq_i),
  .lp_wfi_en_i   (lp_wfi_en_i),
  .wfi_aux_sel_i (wfi_aux_sel_i),
  .pll_keep_i    (pll_keep_i),
  .aux_present_i (aux_present_i),
  .sw_write_i    (sw_write_i),
  .src_sel_o     (src_sel_o),
  .pll_en_o      (pll_en_o),
  .xtal_en_o     (xtal_en_o),
  .cpu_clk_en_o  (cpu_clk_en_o)
);

// File: tb/wfi_clkctl_tb.sv
module wfi_clkctl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wfi_enter = 1'b0, irq = 1'b0, lp_en = 1'b0, aux_sel = 1'b0;
  logic       xtal_stop = 1'b0, pll_keep = 1'b0, aux_present = 1'b0;
  logic       sw_write = 1'b0, sw_pll = 1'b0;
  logic [1:0] sw_src = 2'd0;
  logic [1:0] src;
  logic       pll_en, xtal_en, gate;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  wfi_clkctl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wfi_enter_i(wfi_enter), .irq_i(irq),
    .lp_wfi_en_i(lp_en), .wfi_aux_sel_i(aux_sel), .xtal_stop_i(xtal_stop),
    .pll_keep_i(pll_keep), .aux_present_i(aux_present), .sw_write_i(sw_write),
    .sw_src_i(sw_src), .sw_pll_en_i(sw_pll), .src_sel_o(src), .pll_en_o(pll_en),
    .xtal_en_o(xtal_en), .cpu_clk_en_o(gate)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask
  task automatic wfi();  wfi_enter = 1'b1; cyc(); wfi_enter = 1'b0; endtask
  task automatic wake(); irq = 1'b1; cyc(); irq = 1'b0; endtask
  task automatic sw_apply(logic [1:0] s, logic p);
    sw_src = s; sw_pll = p; sw_write = 1'b1; cyc(); sw_write = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "src", src, 1); chk("R1", "pll", pll_en, 0);
    chk("R1", "xtal", xtal_en, 1); chk("R1", "gate", gate, 1);
  endtask

  task automatic t_plain_wfi();
    lp_en = 1'b0; wfi();
    chk("R2", "gate", gate, 0); chk("R2", "src", src, 1); chk("R2", "pll", pll_en, 0);
    wake();
    chk("R8", "gate", gate, 1); chk("R8", "src", src, 1);
  endtask

  task automatic t_lp_div16();
    sw_apply(2'd0, 1'b0);
    chk("R9", "src pll", src, 0); chk("R9", "pll forced", pll_en, 1);
    lp_en = 1'b1; pll_keep = 1'b0; wfi();
    chk("R3", "src", src, 2); chk("R3", "pll", pll_en, 0); chk("R3", "gate", gate, 0);
    sw_apply(2'd1, 1'b0);
    chk("R9", "src in wfi", src, 1); chk("R9", "gate kept", gate, 0);
    wfi();
    chk("R12", "src asleep entry", src, 1); chk("R12", "gate", gate, 0);
    wake();
    chk("R8", "gate", gate, 1); chk("R8", "src", src, 1); chk("R8", "pll", pll_en, 0);
  endtask

  task automatic t_pll_keep();
    sw_apply(2'd0, 1'b1);
    pll_keep = 1'b1; wfi();
    chk("R4", "src", src, 2); chk("R4", "pll", pll_en, 1);
    wake(); pll_keep = 1'b0;
    chk("R8", "pll after wake", pll_en, 1);
  endtask

  task automatic t_aux_entry();
    aux_present = 1'b1; aux_sel = 1'b1; lp_en = 1'b1;
    sw_apply(2'd1, 1'b0);
    wfi();
    chk("R5", "src", src, 3); chk("R5", "xtal", xtal_en, 0);
    wake();
    chk("R8", "src aux", src, 3); chk("R5", "xtal after wake", xtal_en, 0);
    sw_apply(2'd1, 1'b0);
    chk("R9", "src back", src, 1); chk("R7", "xtal", xtal_en, 1);
  endtask

  task automatic t_aux_absent();
    aux_present = 1'b0; aux_sel = 1'b1; lp_en = 1'b1; wfi();
    chk("R6", "src", src, 2); chk("R6", "xtal", xtal_en, 1);
    wake(); aux_sel = 1'b0;
  endtask

  task automatic t_xtal_rules();
    aux_present = 1'b1; xtal_stop = 1'b1;
    sw_apply(2'd1, 1'b0);
    chk("R7", "xtal not aux", xtal_en, 1);
    sw_apply(2'd3, 1'b0);
    chk("R7", "src", src, 3); chk("R7", "xtal stopped", xtal_en, 0);
    xtal_stop = 1'b0; cyc();
    chk("R7", "xtal released", xtal_en, 1);
  endtask

  task automatic t_sw_absent();
    aux_present = 1'b0;
    sw_apply(2'd3, 1'b0);
    chk("R10", "src", src, 2); chk("R10", "xtal", xtal_en, 1);
  endtask

  task automatic t_fallback();
    aux_present = 1'b1;
    sw_apply(2'd3, 1'b0);
    xtal_stop = 1'b1; cyc();
    chk("R11", "xtal before", xtal_en, 0);
    aux_present = 1'b0; cyc();
    chk("R11", "src", src, 2); chk("R11", "xtal", xtal_en, 1);
    xtal_stop = 1'b0;
  endtask

  task automatic t_collide();
    lp_en = 1'b1;
    sw_apply(2'd1, 1'b0);
    wfi_enter = 1'b1; irq = 1'b1; cyc(); wfi_enter = 1'b0; irq = 1'b0;
    chk("R12", "gate with irq", gate, 1); chk("R12", "src with irq", src, 1);
    sw_src = 2'd0; sw_pll = 1'b1; sw_write = 1'b1; wfi_enter = 1'b1; cyc();
    sw_write = 1'b0; wfi_enter = 1'b0;
    chk("R12", "src entry over write", src, 2); chk("R12", "pll", pll_en, 0);
    chk("R12", "gate", gate, 0);
    wake();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1; cyc();
    t_reset();
    t_plain_wfi();
    t_lp_div16();
    t_pll_keep();
    t_aux_entry();
    t_aux_absent();
    t_xtal_rules();
    t_sw_absent();
    t_fallback();
    t_collide();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule